// File: doc/BRIEF.md
# Queue Interrupt Chain Aggregator

This block folds the event causes of many receive and transmit queues onto a small set of interrupt vectors. Each vector owns a head register that starts a software-built chain of per-queue control entries. Every queue has one receive entry and one transmit entry. Each entry names the next entry in the chain, by index and by type, and carries its own cause-enable bit. A single walker steps through the chains one entry per clock. When it finds a latched queue event whose entry is enabled, it raises the vector that owns the chain. The vector then disarms itself until software re-arms it.

Vector 0 belongs to the non-queue ("other") causes, such as an administrative event. In normal mode, queue chains hang off vectors 1 and up. In legacy single-vector mode, the walker follows only the chain of vector 0. Each hit then sets a bit of a shared cause register, and a per-entry field selects which bit. Vector 0 fires whenever that register holds any cause.

Software reaches the head registers, the entries, the per-vector control registers and the cause register through a plain write/read port. Each fire comes with the ITR-index tag of the entry that caused it, for an external moderator.

Top module: `queue_irq_chain`

## Requirements
- R1: After reset, every vector is disarmed with no pending bit, every head reads 0x7FF, the cause register reads 0, no queue event is latched, and `vecFire` and `loopErr` are low.
- R2: A head register (region 0) holds the first queue index in bits [10:0] and its type in bit 11 (0 = receive, 1 = transmit). An index that is not below the queue count, 0x7FF included, marks the chain as empty, and an empty chain never fires.
- R3: A queue event is latched until the walker consumes it. When an enabled, latched entry is found on the chain of an armed vector v (1 or more, normal mode), `vecFire[v]` pulses for one cycle and `fireItr` carries that entry's bits [17:16]. Entry layout: [10:0] next index, [11] next type, [15:12] vector field, [17:16] ITR index, [20:18] cause-0 bit, [31] cause enable. Receive entries are region 1 and transmit entries region 2.
- R4: An entry whose cause-enable bit is clear never produces a fire, and its event stays latched. Other entries on the same chain still fire. Setting the bit later lets the held event fire.
- R5: A write to a vector control register (region 3) loads bit 0 as the arm flag; bit 1 set clears the pending bit. A read returns the arm flag in bit 0 and the pending bit in bit 2. A fire clears the arm flag and sets the pending bit, so there is no further fire until the vector is re-armed.
- R6: A write to a head register while its vector is armed has no effect.
- R7: A chain may mix receive and transmit entries of different queues, and the walker follows the next fields from entry to entry.
- R8: If a walk visits twice the queue count of entries without reaching the end of the chain, `loopErr` pulses for one cycle and the walk is dropped without firing.
- R9: In legacy mode, only the chain of vector 0 is walked. A hit sets cause bit [20:18] of the entry (value 7 sets nothing and leaves the event latched), whether or not vector 0 is armed. Vector 0 fires when it is armed and the cause register is non-zero.
- R10: The cause register (region 4) returns its value on a read and is cleared by that read. `otherEvent` sets bit 7 in either mode. In normal mode, bits 6:0 never become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | 1 selects single-vector cause mode |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | [7:5] region, [4:0] index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| rxEvent | input | NQ | Receive queue event pulses |
| txEvent | input | NQ | Transmit queue event pulses |
| otherEvent | input | 1 | Non-queue cause pulse |
| vecFire | output | NV | One-cycle vector request per vector |
| fireItr | output | 2 | ITR index tag of the latest queue-vector fire |
| loopErr | output | 1 | One-cycle pulse when the hop guard trips |

## Verification
Register writes take effect at the next edge, and a read's data appears on the cycle after `rdEn`, so the bench samples one clock later at the falling edge. A queue event is latched one edge after it is driven. The fire then follows once the walker reaches the entry, which takes up to NV scan cycles plus 2·NQ hops and one output register. The bench therefore counts fires over a fixed window well beyond that bound before comparing counts, tags and control readback. A legacy cause bit lands one edge after the hit, and vector 0 fires one edge later. A cause read is issued only after the same window.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int IDX_W = 11;
  localparam int VEC_W = 4;
  localparam int HEAD_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] EOL = 11'h7FF;

  localparam logic [2:0] RG_HEAD = 3'd0;
  localparam logic [2:0] RG_RXC = 3'd1;
  localparam logic [2:0] RG_TXC = 3'd2;
  localparam logic [2:0] RG_DYN = 3'd3;
  localparam logic [2:0] RG_CAUSE = 3'd4;

  typedef struct packed {
    logic causeEna;
    logic [2:0] c0Bit;
    logic [1:0] itrIdx;
    logic [VEC_W-1:0] vecIdx;
    logic nextTx;
    logic [IDX_W-1:0] nextIdx;
  } qEntry_t;

  typedef struct packed {
    logic hit;
    logic hitTx;
    logic [IDX_W-1:0] hitIdx;
    logic raiseVec;
    logic [VEC_W-1:0] vec;
    logic [1:0] itr;
    logic setCause;
    logic [2:0] causeBit;
    logic loopTrip;
  } walkStrobe_t;

  function automatic qEntry_t unpackEntry(input logic [31:0] w);
    qEntry_t e;
    e.nextIdx = w[10:0];
    e.nextTx = w[11];
    e.vecIdx = w[15:12];
    e.itrIdx = w[17:16];
    e.c0Bit = w[20:18];
    e.causeEna = w[31];
    return e;
  endfunction

  function automatic logic [31:0] packEntry(input qEntry_t e);
    return {e.causeEna, 10'b0, e.c0Bit, e.itrIdx, e.vecIdx, e.nextTx, e.nextIdx};
  endfunction
endpackage

// File: rtl/qirq_walk.sv
module qirq_walk
  import qirq_pkg::*;
#(
  parameter int NQ = 4,
  parameter int NV = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic legacyMode,
  input  logic [IDX_W-1:0] headIdx,
  input  logic headTx,
  input  logic [NV-1:0] vecEna,
  input  logic [IDX_W-1:0] entNextIdx,
  input  logic entNextTx,
  input  logic [1:0] entItr,
  input  logic [2:0] entC0Bit,
  input  logic entEna,
  input  logic curPend,
  output logic [VEC_W-1:0] walkVec,
  output logic [IDX_W-1:0] ptrIdx,
  output logic ptrTx,
  output walkStrobe_t strobe
);
  localparam int MAX_HOPS = 2 * NQ;
  localparam int HOP_W = $clog2(MAX_HOPS + 1);
  localparam logic [IDX_W-1:0] NQ_I = IDX_W'(NQ);
  localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NV - 1);

  typedef enum logic {ST_SCAN, ST_WALK} walkState_t;
  walkState_t state;
  logic [HOP_W-1:0] hops;

  logic vecOn, headOk, nextOk, startWalk, pendHit, legHit, msixHit, lastHop, endWalk;
  logic [VEC_W-1:0] nextVec;

  always_comb begin
    vecOn = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (walkVec == VEC_W'(v)) vecOn = vecEna[v];
    end
    headOk = headIdx < NQ_I;
    nextOk = entNextIdx < NQ_I;
    startWalk = headOk && (legacyMode ? (walkVec == '0) : (walkVec != '0 && vecOn));
    if (legacyMode) nextVec = '0;
    else if (walkVec >= LAST_VEC) nextVec = VEC_W'(1);
    else nextVec = walkVec + VEC_W'(1);
    pendHit = (state == ST_WALK) && entEna && curPend;
    legHit = pendHit && legacyMode && (entC0Bit != 3'd7);
    msixHit = pendHit && !legacyMode && vecOn;
    lastHop = hops == HOP_W'(MAX_HOPS - 1);
    endWalk = msixHit || !nextOk || lastHop;

    strobe.hit = legHit || msixHit;
    strobe.hitTx = ptrTx;
    strobe.hitIdx = ptrIdx;
    strobe.raiseVec = msixHit;
    strobe.vec = walkVec;
    strobe.itr = entItr;
    strobe.setCause = legHit;
    strobe.causeBit = entC0Bit;
    strobe.loopTrip = (state == ST_WALK) && lastHop && nextOk && !msixHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_SCAN;
      walkVec <= '0;
      ptrIdx <= EOL;
      ptrTx <= 1'b0;
      hops <= '0;
    end else if (state == ST_SCAN) begin
      if (startWalk) begin
        ptrIdx <= headIdx;
        ptrTx <= headTx;
        hops <= '0;
        state <= ST_WALK;
      end else begin
        walkVec <= nextVec;
      end
    end else begin
      if (endWalk) begin
        state <= ST_SCAN;
        walkVec <= nextVec;
      end else begin
        ptrIdx <= entNextIdx;
        ptrTx <= entNextTx;
        hops <= hops + HOP_W'(1);
      end
    end
  end
endmodule

// File: rtl/qirq_regs.sv
module qirq_regs
  import qirq_pkg::*;
#(
  parameter int NQ = 4,
  parameter int NV = 5,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [NQ-1:0] rxEvent,
  input  logic [NQ-1:0] txEvent,
  input  logic otherEvent,
  input  walkStrobe_t strobe,
  input  logic [VEC_W-1:0] walkVec,
  input  logic [IDX_W-1:0] ptrIdx,
  input  logic ptrTx,
  output logic [IDX_W-1:0] headIdx,
  output logic headTx,
  output logic [IDX_W-1:0] entNextIdx,
  output logic entNextTx,
  output logic [1:0] entItr,
  output logic [2:0] entC0Bit,
  output logic entEna,
  output logic curPend,
  output logic [NV-1:0] vecEna,
  output logic [NV*HEAD_W-1:0] headFlat,
  output logic [7:0] cause0,
  output logic [NV-1:0] vecFire,
  output logic [1:0] fireItr,
  output logic loopErr
);
  localparam int SEL_W = ADDR_W - 3;

  logic [IDX_W-1:0] headIdxQ [NV];
  logic headTxQ [NV];
  qEntry_t rxEnt [NQ];
  qEntry_t txEnt [NQ];
  logic [NV-1:0] vecPba;
  logic [NQ-1:0] rxPend, txPend;

  logic [2:0] region;
  logic [SEL_W-1:0] regIdx;
  logic [31:0] readMux;
  logic [7:0] causeSet;
  logic fire0;
  qEntry_t curEnt;

  assign region = addr[ADDR_W-1:ADDR_W-3];
  assign regIdx = addr[SEL_W-1:0];

  always_comb begin
    headIdx = EOL;
    headTx = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (walkVec == VEC_W'(v)) begin
        headIdx = headIdxQ[v];
        headTx = headTxQ[v];
      end
      headFlat[v*HEAD_W +: HEAD_W] = {headTxQ[v], headIdxQ[v]};
    end
    curEnt = unpackEntry({1'b0, 20'b0, EOL});
    curPend = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      if (ptrIdx == IDX_W'(q)) begin
        curEnt = ptrTx ? txEnt[q] : rxEnt[q];
        curPend = ptrTx ? txPend[q] : rxPend[q];
      end
    end
    entNextIdx = curEnt.nextIdx;
    entNextTx = curEnt.nextTx;
    entItr = curEnt.itrIdx;
    entC0Bit = curEnt.c0Bit;
    entEna = curEnt.causeEna;
  end

  always_comb begin
    readMux = '0;
    case (region)
      RG_HEAD: for (int v = 0; v < NV; v++)
        if (regIdx == SEL_W'(v)) readMux = {20'b0, headTxQ[v], headIdxQ[v]};
      RG_RXC: for (int q = 0; q < NQ; q++)
        if (regIdx == SEL_W'(q)) readMux = packEntry(rxEnt[q]);
      RG_TXC: for (int q = 0; q < NQ; q++)
        if (regIdx == SEL_W'(q)) readMux = packEntry(txEnt[q]);
      RG_DYN: for (int v = 0; v < NV; v++)
        if (regIdx == SEL_W'(v)) readMux = {29'b0, vecPba[v], 1'b0, vecEna[v]};
      RG_CAUSE: readMux = {24'b0, cause0};
      default: readMux = '0;
    endcase
    causeSet = {otherEvent, 7'b0};
    if (strobe.setCause) causeSet = causeSet | (8'd1 << strobe.causeBit);
    fire0 = vecEna[0] && (cause0 != 8'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < NV; v++) begin
        headIdxQ[v] <= EOL;
        headTxQ[v] <= 1'b0;
      end
      for (int q = 0; q < NQ; q++) begin
        rxEnt[q] <= unpackEntry({1'b0, 20'b0, EOL});
        txEnt[q] <= unpackEntry({1'b0, 20'b0, EOL});
      end
      vecEna <= '0;
      vecPba <= '0;
      rxPend <= '0;
      txPend <= '0;
      cause0 <= '0;
      vecFire <= '0;
      fireItr <= '0;
      loopErr <= 1'b0;
      rdData <= '0;
    end else begin
      if (rdEn) rdData <= readMux;
      for (int v = 0; v < NV; v++) begin
        if (wrEn && region == RG_HEAD && regIdx == SEL_W'(v) && !vecEna[v]) begin
          headIdxQ[v] <= wrData[IDX_W-1:0];
          headTxQ[v] <= wrData[IDX_W];
        end
        if (wrEn && region == RG_DYN && regIdx == SEL_W'(v)) begin
          vecEna[v] <= wrData[0];
          if (wrData[1]) vecPba[v] <= 1'b0;
        end
      end
      for (int q = 0; q < NQ; q++) begin
        if (wrEn && region == RG_RXC && regIdx == SEL_W'(q)) rxEnt[q] <= unpackEntry(wrData);
        if (wrEn && region == RG_TXC && regIdx == SEL_W'(q)) txEnt[q] <= unpackEntry(wrData);
        rxPend[q] <= (rxPend[q] && !(strobe.hit && !strobe.hitTx && strobe.hitIdx == IDX_W'(q)))
                     || rxEvent[q];
        txPend[q] <= (txPend[q] && !(strobe.hit && strobe.hitTx && strobe.hitIdx == IDX_W'(q)))
                     || txEvent[q];
      end
      if (rdEn && region == RG_CAUSE) cause0 <= causeSet;
      else cause0 <= cause0 | causeSet;

      vecFire <= '0;
      loopErr <= strobe.loopTrip;
      for (int v = 1; v < NV; v++) begin
        if (strobe.raiseVec && strobe.vec == VEC_W'(v)) begin
          vecFire[v] <= 1'b1;
          vecEna[v] <= 1'b0;
          vecPba[v] <= 1'b1;
        end
      end
      if (strobe.raiseVec) fireItr <= strobe.itr;
      if (fire0) begin
        vecFire[0] <= 1'b1;
        vecEna[0] <= 1'b0;
        vecPba[0] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/queue_irq_chain.sv
module queue_irq_chain
  import qirq_pkg::*;
#(
  parameter int NQ = 4,
  parameter int NV = 5,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic legacyMode,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [NQ-1:0] rxEvent,
  input  logic [NQ-1:0] txEvent,
  input  logic otherEvent,
  output logic [NV-1:0] vecFire,
  output logic [1:0] fireItr,
  output logic loopErr
);
  walkStrobe_t strobe;
  logic [VEC_W-1:0] walkVec;
  logic [IDX_W-1:0] ptrIdx, headIdx, entNextIdx;
  logic ptrTx, headTx, entNextTx, entEna, curPend;
  logic [1:0] entItr;
  logic [2:0] entC0Bit;
  logic [NV-1:0] vecEna;
  logic [NV*HEAD_W-1:0] headFlat;
  logic [7:0] cause0;

  qirq_walk #(.NQ(NQ), .NV(NV)) u_walk (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .headIdx(headIdx), .headTx(headTx), .vecEna(vecEna),
    .entNextIdx(entNextIdx), .entNextTx(entNextTx), .entItr(entItr),
    .entC0Bit(entC0Bit), .entEna(entEna), .curPend(curPend),
    .walkVec(walkVec), .ptrIdx(ptrIdx), .ptrTx(ptrTx), .strobe(strobe)
  );

  qirq_regs #(.NQ(NQ), .NV(NV), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxEvent(rxEvent), .txEvent(txEvent),
    .otherEvent(otherEvent), .strobe(strobe), .walkVec(walkVec),
    .ptrIdx(ptrIdx), .ptrTx(ptrTx), .headIdx(headIdx), .headTx(headTx),
    .entNextIdx(entNextIdx), .entNextTx(entNextTx), .entItr(entItr),
    .entC0Bit(entC0Bit), .entEna(entEna), .curPend(curPend),
    .vecEna(vecEna), .headFlat(headFlat), .cause0(cause0),
    .vecFire(vecFire), .fireItr(fireItr), .loopErr(loopErr)
  );
endmodule

// File: rtl/qirq_chk.sv
module qirq_chk
  import qirq_pkg::*;
#(
  parameter int NQ = 4,
  parameter int NV = 5
) (
  input logic clk,
  input logic rstN,
  input logic legacyMode,
  input logic [NV-1:0] vecFire,
  input logic [NV-1:0] vecEna,
  input logic [NV*HEAD_W-1:0] headFlat,
  input logic [7:0] cause0
);
  logic [NV*HEAD_W-1:0] enaWide;
  always_comb begin
    for (int v = 0; v < NV; v++) enaWide[v*HEAD_W +: HEAD_W] = {HEAD_W{vecEna[v]}};
  end

  // R5: a firing vector is disarmed in the same cycle it fires
  p_fire_disarms_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecFire & vecEna) == '0);

  // R5: only an armed vector can fire
  p_fire_needs_ena_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecFire & ~$past(vecEna)) == '0);

  // R3: one queue vector request at a time
  p_one_queue_fire_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vecFire[NV-1:1]));

  // R6: an armed vector's head does not move
  p_head_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((headFlat ^ $past(headFlat)) & $past(enaWide)) == '0);

  // R9: vector 0 fires only on a non-empty cause register
  p_vec0_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    vecFire[0] |-> $past(cause0 != 8'd0));

  // R10: normal mode never sets queue cause bits
  p_no_queue_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(legacyMode) && $past(cause0[6:0]) == 7'd0) |-> cause0[6:0] == 7'd0);
endmodule

bind queue_irq_chain qirq_chk #(.NQ(NQ), .NV(NV)) u_chk (
  .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .vecFire(vecFire),
  .vecEna(vecEna), .headFlat(headFlat), .cause0(cause0)
);

// File: tb/queue_irq_chain_bench.sv
module queue_irq_chain_bench;
  localparam int NQ = 4;
  localparam int NV = 5;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic legacyMode = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NQ-1:0] rxEvent = '0, txEvent = '0;
  logic otherEvent = 1'b0;
  logic [NV-1:0] vecFire;
  logic [1:0] fireItr;
  logic loopErr;

  int checks = 0;
  int errors = 0;
  int fireCnt [NV];
  int loopCnt = 0;
  logic [1:0] lastItr = '0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  queue_irq_chain u_queue_irq_chain (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rxEvent(rxEvent),
    .txEvent(txEvent), .otherEvent(otherEvent), .vecFire(vecFire),
    .fireItr(fireItr), .loopErr(loopErr)
  );

  function automatic logic [7:0] ra(input int region, input int idx);
    return {region[2:0], idx[4:0]};
  endfunction

  function automatic logic [31:0] ent(input int nxt, input int nxtTx, input int itr,
                                      input int c0, input int ena);
    return {ena[0], 10'b0, c0[2:0], itr[1:0], 4'b0, nxtTx[0], nxt[10:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulse(input logic [NQ-1:0] rx, input logic [NQ-1:0] tx, input logic oth);
    @(negedge clk);
    rxEvent = rx; txEvent = tx; otherEvent = oth;
    @(negedge clk);
    rxEvent = '0; txEvent = '0; otherEvent = 1'b0;
  endtask

  task automatic watch(input int n);
    for (int v = 0; v < NV; v++) fireCnt[v] = 0;
    loopCnt = 0;
    repeat (n) begin
      @(negedge clk);
      for (int v = 0; v < NV; v++) if (vecFire[v]) begin
        fireCnt[v]++;
        if (v != 0) lastItr = fireItr;
      end
      if (loopErr) loopCnt++;
    end
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog R1 actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 vecFire", {27'b0, vecFire}, 32'h0);
    chk("R1 loopErr", {31'b0, loopErr}, 32'h0);
    regRd(ra(0, 1), rd); chk("R1 head1", rd, 32'h7FF);
    regRd(ra(3, 2), rd); chk("R1 dyn2", rd, 32'h0);
    regRd(ra(4, 0), rd); chk("R1 cause0", rd, 32'h0);
    watch(WIN);
    chk("R1 no fire", 32'(fireCnt[1] + fireCnt[2] + fireCnt[3] + fireCnt[4] + fireCnt[0]), 32'h0);

    // R2/R3: normal chains, queue q on vector q+1, rx -> tx -> end
    for (int q = 0; q < NQ; q++) begin
      regWr(ra(0, q + 1), 32'(q));
      regWr(ra(1, q), ent(q, 1, 0, 7, 1));
      regWr(ra(2, q), ent(2047, 0, 1, 7, 1));
      regWr(ra(3, q + 1), 32'h3);
    end
    regRd(ra(1, 2), rd); chk("R3 entry readback", rd, ent(2, 1, 0, 7, 1));
    regRd(ra(0, 3), rd); chk("R2 head readback", rd, 32'h2);

    // R3/R5: sweep every queue and type
    for (int q = 0; q < NQ; q++) begin
      for (int t = 0; t < 2; t++) begin
        pulse(t == 0 ? NQ'(1 << q) : '0, t == 1 ? NQ'(1 << q) : '0, 1'b0);
        watch(WIN);
        chk($sformatf("R3 fire q%0d t%0d", q, t), 32'(fireCnt[q + 1]), 32'h1);
        chk("R3 total fires", 32'(fireCnt[0] + fireCnt[1] + fireCnt[2] + fireCnt[3] + fireCnt[4]), 32'h1);
        chk("R3 itr tag", {30'b0, lastItr}, 32'(t));
        regRd(ra(3, q + 1), rd); chk("R5 disarm and pending", rd, 32'h4);
        regWr(ra(3, q + 1), 32'h3);
        regRd(ra(3, q + 1), rd); chk("R5 rearm clears pending", rd, 32'h1);
      end
    end

    // R5: no refire while disarmed, held event fires on rearm
    pulse(4'b0001, '0, 1'b0); watch(WIN);
    chk("R5 first fire", 32'(fireCnt[1]), 32'h1);
    pulse(4'b0001, '0, 1'b0); watch(WIN);
    chk("R5 no refire", 32'(fireCnt[1]), 32'h0);
    regWr(ra(3, 1), 32'h3); watch(WIN);
    chk("R5 fire after rearm", 32'(fireCnt[1]), 32'h1);

    // R4: cause enable gating on queue 1
    regWr(ra(1, 1), ent(1, 1, 0, 7, 0));
    pulse(4'b0010, 4'b0010, 1'b0); watch(WIN);
    chk("R4 tx still fires", 32'(fireCnt[2]), 32'h1);
    chk("R4 tx itr", {30'b0, lastItr}, 32'h1);
    regWr(ra(3, 2), 32'h3); watch(WIN);
    chk("R4 disabled rx silent", 32'(fireCnt[2]), 32'h0);
    regWr(ra(1, 1), ent(1, 1, 0, 7, 1)); watch(WIN);
    chk("R4 held rx fires", 32'(fireCnt[2]), 32'h1);
    chk("R4 rx itr", {30'b0, lastItr}, 32'h0);

    // R6: head write while armed ignored
    regWr(ra(3, 2), 32'h3);
    regWr(ra(0, 2), 32'h7FF);
    regRd(ra(0, 2), rd); chk("R6 head kept", rd, 32'h1);
    regWr(ra(3, 2), 32'h0);
    regWr(ra(0, 2), 32'h7FF);
    regRd(ra(0, 2), rd); chk("R6 head written when disarmed", rd, 32'h7FF);
    regWr(ra(3, 2), 32'h3);
    pulse(4'b0010, '0, 1'b0); watch(WIN);
    chk("R2 empty chain silent", 32'(fireCnt[2]), 32'h0);
    regWr(ra(3, 2), 32'h0);
    regWr(ra(0, 2), 32'h1);
    regWr(ra(3, 2), 32'h3); watch(WIN);
    chk("R2 restored chain fires", 32'(fireCnt[2]), 32'h1);

    // R7: mixed chain rx0 -> tx0 -> rx3 -> tx3 on vector 1
    regWr(ra(3, 4), 32'h0);
    regWr(ra(0, 4), 32'h7FF);
    regWr(ra(3, 1), 32'h0);
    regWr(ra(2, 0), ent(3, 0, 1, 7, 1));
    regWr(ra(3, 1), 32'h3);
    regWr(ra(3, 4), 32'h3);
    pulse('0, 4'b1000, 1'b0); watch(WIN);
    chk("R7 tail of mixed chain", 32'(fireCnt[1]), 32'h1);
    chk("R7 tag", {30'b0, lastItr}, 32'h1);
    chk("R7 old vector silent", 32'(fireCnt[4]), 32'h0);

    // R8: self loop trips the hop guard
    regWr(ra(1, 0), ent(0, 0, 0, 7, 0));
    regWr(ra(3, 1), 32'h3);
    watch(WIN);
    chk("R8 loopErr seen", 32'(loopCnt != 0), 32'h1);
    chk("R8 no fire", 32'(fireCnt[1]), 32'h0);
    regWr(ra(3, 1), 32'h0);

    // R10: other cause in normal mode
    regWr(ra(3, 0), 32'h3);
    pulse('0, '0, 1'b1); watch(WIN);
    chk("R10 vec0 fires on other", 32'(fireCnt[0]), 32'h1);
    regRd(ra(4, 0), rd); chk("R10 other bit", rd, 32'h80);
    regRd(ra(4, 0), rd); chk("R10 read clears", rd, 32'h0);

    // R9: legacy mode on chain of vector 0
    @(negedge clk); legacyMode = 1'b1;
    regWr(ra(0, 0), 32'h0);
    regWr(ra(2, 0), ent(2047, 0, 1, 1, 1));
    for (int b = 0; b < 8; b++) begin
      regWr(ra(1, 0), ent(0, 1, 0, b, 1));
      pulse(4'b0001, '0, 1'b0); watch(WIN);
      regRd(ra(4, 0), rd);
      chk($sformatf("R9 cause bit %0d", b), rd, b == 7 ? 32'h0 : 32'(1 << b));
      chk("R9 disarmed vec0 silent", 32'(fireCnt[0]), 32'h0);
    end
    regWr(ra(1, 0), ent(0, 1, 0, 0, 0));
    regWr(ra(3, 0), 32'h3);
    pulse('0, 4'b0001, 1'b0); watch(WIN);
    chk("R9 vec0 fires", 32'(fireCnt[0]), 32'h1);
    chk("R9 no queue vector", 32'(fireCnt[1] + fireCnt[2] + fireCnt[3] + fireCnt[4]), 32'h0);
    regRd(ra(4, 0), rd); chk("R9 tx cause bit", rd, 32'h2);
    regWr(ra(2, 0), ent(2047, 0, 1, 1, 0));
    pulse('0, 4'b0001, 1'b0); watch(WIN);
    regRd(ra(4, 0), rd); chk("R9 gated by cause enable", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule